// File: doc/BRIEF.md
# Token-Ring Register Bridge Between Two Clock Domains

This block carries the contents of a register between two unrelated clocks: a user clock that runs the application logic and a bus clock that serves a host. A single token circulates around a ring of seven flip-flops. Three of them run on the user clock and four on the bus clock. The ring contains one inverting stage, so the token flips polarity on every lap and circulates without stopping. When a token transition reaches the end of one domain's segment, that domain gets a one-cycle load enable. The user side and the bus side therefore take turns, and neither side copies a register while the other side is changing it.

In the upload direction, an application value is sampled into a user-clock holding register. It is then copied into a bus-clock output register that the host reads. This repeats on every lap with no request, so the host may read the same value many times.

In the download direction, a host write is parked on the bus side until the next bus enable. It is then launched together with its data, and on the next user enable it appears as a single-cycle strobe carrying that data. One ring serves every bit in both directions.

Top module: `xdom_reg_bridge`

## Requirements
- R1: While the resets are asserted, `bus_rd_data` and `usr_wr_data` are zero and `usr_wr_stb` is low.
- R2: Every value seen on `bus_rd_data` is one complete word that `up_data` held earlier. Bits from two different words are never combined.
- R3: The words seen on `bus_rd_data` appear in the same order in which they were presented on `up_data`. An older word never replaces a newer one.
- R4: The copy repeats with no request. While `up_data` changes on every user cycle, `bus_rd_data` takes a new value at least once every 16 bus cycles. While `up_data` is held, repeated reads return the identical word.
- R5: After `up_data` settles on a new word, `bus_rd_data` equals that word within 30 bus cycles.
- R6: Each single-cycle host write (`bus_wr_stb` high for one bus cycle) produces exactly one `usr_wr_stb` pulse, exactly one user cycle wide. In that cycle `usr_wr_data` carries the data written. `usr_wr_data` then keeps that value until the next delivered write.
- R7: A host write is delivered on the user side within 40 user cycles.
- R8: No write is lost or duplicated, at any phase of the write relative to the ring. This includes a write that arrives in the same bus cycle as a bus-side enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_u | input | 1 | User (application) clock |
| rst_u | input | 1 | Synchronous active-high reset, user domain |
| clk_b | input | 1 | Bus (host side) clock |
| rst_b | input | 1 | Synchronous active-high reset, bus domain |
| up_data | input | W | Application value offered to the host |
| usr_wr_stb | output | 1 | One-cycle pulse marking a delivered host write |
| usr_wr_data | output | W | Data of the last delivered host write |
| bus_wr_stb | input | 1 | Host write strobe, one bus cycle |
| bus_wr_data | input | W | Host write data, valid with `bus_wr_stb` |
| bus_rd_data | output | W | Copy of the application value read by the host |

## Verification
On the bus side, a host write can land in the same cycle as the periodic copy enable. At that moment the parked write is launched while a new strobe arrives, and the two must merge into exactly one delivered write. The bench sweeps the idle gap before each write through every value from 0 to 23 bus cycles. The user-clock period is 20·√2 ns against the 20 ns bus clock, so this slides each write across all ring phases. Every write is judged by counting user-side strobes (exactly one, one cycle wide) and comparing the delivered data.

In the upload direction, every user cycle drives a self-describing word: an index in the upper half and its complement in the lower half. Any torn or reordered copy is therefore visible arithmetically.

// File: rtl/xdom_pkg.sv
package xdom_pkg;

    // Ring split: stages clocked by the user clock and by the bus clock.
    localparam int U_STAGES = 3;
    localparam int B_STAGES = 4;
    localparam int DEF_W    = 32;

    // Per-domain enables of the ring, each valid only in its own domain.
    typedef struct packed {
        logic u_load;
        logic b_load;
    } ring_en_t;

    // A token transition is present between two adjacent stages.
    function automatic logic token_edge(input logic last_q, input logic prev_q);
        return last_q ^ prev_q;
    endfunction

endpackage

// File: rtl/xdom_token_ring.sv
module xdom_token_ring
    import xdom_pkg::*;
#(
    parameter int US = U_STAGES,
    parameter int BS = B_STAGES
) (
    input  logic     clk_u,
    input  logic     rst_u,
    input  logic     clk_b,
    input  logic     rst_b,
    output ring_en_t en
);

    logic [US-1:0] u_q;
    logic [BS-1:0] b_q;

    // User segment: stage 0 receives the inverted token from the bus side
    // and serves as the first synchronizer flop.
    always_ff @(posedge clk_u) begin
        if (rst_u) u_q <= '0;
        else       u_q <= {u_q[US-2:0], ~b_q[BS-1]};
    end

    // Bus segment: stage 0 receives the token from the user side.
    always_ff @(posedge clk_b) begin
        if (rst_b) b_q <= '0;
        else       b_q <= {b_q[BS-2:0], u_q[US-1]};
    end

    // Decode uses only the stages behind the first synchronizer flop.
    always_comb begin
        en.u_load = token_edge(u_q[US-1], u_q[US-2]);
        en.b_load = token_edge(b_q[BS-1], b_q[BS-2]);
    end

endmodule

// File: rtl/xdom_upload.sv
module xdom_upload #(
    parameter int W = 32
) (
    input  logic         clk_u,
    input  logic         rst_u,
    input  logic         clk_b,
    input  logic         rst_b,
    input  logic         u_load,
    input  logic         b_load,
    input  logic [W-1:0] up_data,
    output logic [W-1:0] hold_u,
    output logic [W-1:0] bus_rd_data
);

    always_ff @(posedge clk_u) begin
        if (rst_u)       hold_u <= '0;
        else if (u_load) hold_u <= up_data;
    end

    always_ff @(posedge clk_b) begin
        if (rst_b)       bus_rd_data <= '0;
        else if (b_load) bus_rd_data <= hold_u;
    end

endmodule

// File: rtl/xdom_download.sv
module xdom_download #(
    parameter int W = 32
) (
    input  logic         clk_u,
    input  logic         rst_u,
    input  logic         clk_b,
    input  logic         rst_b,
    input  logic         u_load,
    input  logic         b_load,
    input  logic         bus_wr_stb,
    input  logic [W-1:0] bus_wr_data,
    output logic         xfer_vld,
    output logic [W-1:0] xfer_dat,
    output logic         usr_wr_stb,
    output logic [W-1:0] usr_wr_data
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } wr_msg_t;

    wr_msg_t park_q;
    wr_msg_t xfer_q;

    // Bus side: park a write, launch it on the bus enable.
    // A write in the enable cycle itself is launched directly.
    always_ff @(posedge clk_b) begin
        if (rst_b) begin
            park_q <= '0;
            xfer_q <= '0;
        end else if (b_load) begin
            xfer_q.vld <= park_q.vld | bus_wr_stb;
            xfer_q.dat <= bus_wr_stb ? bus_wr_data : park_q.dat;
            park_q.vld <= 1'b0;
        end else if (bus_wr_stb) begin
            park_q.vld <= 1'b1;
            park_q.dat <= bus_wr_data;
        end
    end

    // User side: one enable per lap, so a launched message is taken once.
    always_ff @(posedge clk_u) begin
        if (rst_u) begin
            usr_wr_stb  <= 1'b0;
            usr_wr_data <= '0;
        end else begin
            usr_wr_stb <= u_load & xfer_q.vld;
            if (u_load && xfer_q.vld) usr_wr_data <= xfer_q.dat;
        end
    end

    assign xfer_vld = xfer_q.vld;
    assign xfer_dat = xfer_q.dat;

endmodule

// File: rtl/xdom_reg_bridge.sv
module xdom_reg_bridge
    import xdom_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk_u,
    input  logic         rst_u,
    input  logic         clk_b,
    input  logic         rst_b,
    input  logic [W-1:0] up_data,
    output logic         usr_wr_stb,
    output logic [W-1:0] usr_wr_data,
    input  logic         bus_wr_stb,
    input  logic [W-1:0] bus_wr_data,
    output logic [W-1:0] bus_rd_data
);

    ring_en_t     en;
    logic         en_u;
    logic         en_b;
    logic [W-1:0] hold_u;
    logic         xfer_vld;
    logic [W-1:0] xfer_dat;

    xdom_token_ring #(.US(U_STAGES), .BS(B_STAGES)) u_ring (
        .clk_u (clk_u),
        .rst_u (rst_u),
        .clk_b (clk_b),
        .rst_b (rst_b),
        .en    (en)
    );

    assign en_u = en.u_load;
    assign en_b = en.b_load;

    xdom_upload #(.W(W)) u_up (
        .clk_u       (clk_u),
        .rst_u       (rst_u),
        .clk_b       (clk_b),
        .rst_b       (rst_b),
        .u_load      (en_u),
        .b_load      (en_b),
        .up_data     (up_data),
        .hold_u      (hold_u),
        .bus_rd_data (bus_rd_data)
    );

    xdom_download #(.W(W)) u_down (
        .clk_u       (clk_u),
        .rst_u       (rst_u),
        .clk_b       (clk_b),
        .rst_b       (rst_b),
        .u_load      (en_u),
        .b_load      (en_b),
        .bus_wr_stb  (bus_wr_stb),
        .bus_wr_data (bus_wr_data),
        .xfer_vld    (xfer_vld),
        .xfer_dat    (xfer_dat),
        .usr_wr_stb  (usr_wr_stb),
        .usr_wr_data (usr_wr_data)
    );

endmodule

// File: rtl/xdom_reg_bridge_chk.sv
module xdom_reg_bridge_chk #(
    parameter int W = 32
) (
    input logic         clk_u,
    input logic         rst_u,
    input logic         clk_b,
    input logic         rst_b,
    input logic         en_u,
    input logic         en_b,
    input logic [W-1:0] hold_u,
    input logic         xfer_vld,
    input logic [W-1:0] xfer_dat,
    input logic         usr_wr_stb,
    input logic [W-1:0] usr_wr_data,
    input logic [W-1:0] bus_rd_data
);

    assert_bus_reset_R1: assert property (@(posedge clk_b)
        rst_b |=> bus_rd_data == '0);

    assert_usr_reset_R1: assert property (@(posedge clk_u)
        rst_u |=> (!usr_wr_stb && usr_wr_data == '0));

    // Bus copy samples the user holding register only while it is quiet.
    assert_hold_quiet_R2: assert property (@(posedge clk_b) disable iff (rst_b || rst_u)
        en_b |-> $stable(hold_u));

    // User side takes the launched write only while it is quiet.
    assert_xfer_quiet_R8: assert property (@(posedge clk_u) disable iff (rst_u || rst_b)
        en_u |-> ($stable(xfer_vld) && $stable(xfer_dat)));

    assert_bus_en_pulse_R4: assert property (@(posedge clk_b) disable iff (rst_b)
        en_b |=> !en_b);

    assert_usr_en_pulse_R4: assert property (@(posedge clk_u) disable iff (rst_u)
        en_u |=> !en_u);

    assert_stb_single_R6: assert property (@(posedge clk_u) disable iff (rst_u)
        usr_wr_stb |=> !usr_wr_stb);

endmodule

bind xdom_reg_bridge xdom_reg_bridge_chk #(.W(W)) u_chk (
    .clk_u       (clk_u),
    .rst_u       (rst_u),
    .clk_b       (clk_b),
    .rst_b       (rst_b),
    .en_u        (en_u),
    .en_b        (en_b),
    .hold_u      (hold_u),
    .xfer_vld    (xfer_vld),
    .xfer_dat    (xfer_dat),
    .usr_wr_stb  (usr_wr_stb),
    .usr_wr_data (usr_wr_data),
    .bus_rd_data (bus_rd_data)
);

// File: tb/sim_xdom_reg_bridge.sv
`timescale 1ns/1ps
module sim_xdom_reg_bridge;

    localparam int W = 32;

    logic         clk_u = 1'b0;
    logic         clk_b = 1'b0;
    logic         rst_u = 1'b1;
    logic         rst_b = 1'b1;
    logic [W-1:0] up_data;
    logic         usr_wr_stb;
    logic [W-1:0] usr_wr_data;
    logic         bus_wr_stb = 1'b0;
    logic [W-1:0] bus_wr_data = '0;
    logic [W-1:0] bus_rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit run_a = 1'b0;
    int k = 0;
    int stb_cnt = 0;
    int wide_cnt = 0;
    logic prev_stb = 1'b0;
    logic [W-1:0] last_seen = '0;

    always #10 clk_b = ~clk_b;        // 50 MHz bus clock
    always #14.142 clk_u = ~clk_u;    // user clock, ratio sqrt(2)

    xdom_reg_bridge #(.W(W)) u0 (
        .clk_u       (clk_u),
        .rst_u       (rst_u),
        .clk_b       (clk_b),
        .rst_b       (rst_b),
        .up_data     (up_data),
        .usr_wr_stb  (usr_wr_stb),
        .usr_wr_data (usr_wr_data),
        .bus_wr_stb  (bus_wr_stb),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data)
    );

    // Self-describing word: index in the upper half, complement below.
    function automatic logic [31:0] enc(input int n);
        logic [15:0] h;
        h = n[15:0];
        return {h, ~h};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Upload stimulus: a new word on every user cycle while enabled.
    initial begin
        up_data = enc(0);
        forever begin
            @(negedge clk_u);
            if (run_a) begin
                k++;
                up_data = enc(k);
            end
        end
    end

    // User-side monitor of delivered writes.
    initial begin
        forever begin
            @(negedge clk_u);
            if (usr_wr_stb) begin
                stb_cnt++;
                last_seen = usr_wr_data;
                if (prev_stb) wide_cnt++;
            end
            prev_stb = usr_wr_stb;
        end
    end

    initial begin
        repeat (200000) @(posedge clk_b);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int prev_d;
        int gap;
        int d;
        logic [31:0] v;
        logic [31:0] cval;
        logic [31:0] dval;
        int base;

        // R1: reset state, with a non-zero word already on up_data
        repeat (6) @(negedge clk_b);
        chk(bus_rd_data == '0, "R1 bus_rd_data in reset", bus_rd_data, 32'h0);
        chk(usr_wr_stb == 1'b0, "R1 usr_wr_stb in reset", {31'b0, usr_wr_stb}, 32'h0);
        chk(usr_wr_data == '0, "R1 usr_wr_data in reset", usr_wr_data, 32'h0);
        @(negedge clk_u) rst_u = 1'b0;
        @(negedge clk_b) rst_b = 1'b0;

        // First copy of the initial word
        for (int i = 0; i < 100; i++) begin
            @(negedge clk_b);
            if (bus_rd_data == enc(0)) break;
        end
        chk(bus_rd_data == enc(0), "R5 first copy", bus_rd_data, enc(0));

        // R2, R3, R4: words change on every user cycle
        run_a = 1'b1;
        prev_d = 0;
        gap = 0;
        repeat (2000) begin
            @(negedge clk_b);
            v = bus_rd_data;
            d = int'(v[31:16]);
            chk(v[15:0] == ~v[31:16], "R2 torn word", v, {v[31:16], ~v[31:16]});
            chk(d <= k, "R2 word not yet presented", v, enc(k));
            chk(d >= prev_d, "R3 order", v, enc(prev_d));
            if (d != prev_d) gap = 0;
            else gap++;
            chk(gap <= 16, "R4 refresh period", gap, 32'd16);
            prev_d = d;
        end
        run_a = 1'b0;

        // R5 latency and R4 repeated reads of a held word
        for (int i = 0; i < 8; i++) begin
            cval = 32'hA5C3_0F00 ^ (i * 32'h1357_9BDF);
            @(negedge clk_u) up_data = cval;
            repeat (30) @(negedge clk_b);
            chk(bus_rd_data == cval, "R5 latency", bus_rd_data, cval);
            repeat (4) begin
                repeat (5) @(negedge clk_b);
                chk(bus_rd_data == cval, "R4 re-read held word", bus_rd_data, cval);
            end
        end

        // R6, R7, R8: host writes swept over every ring phase
        for (int g = 0; g < 24; g++) begin
            @(negedge clk_b);
            base = stb_cnt;
            dval = (32'h1000_0000 + g * 32'h0101_0101) ^ 32'h00FF_3C00;
            bus_wr_stb = 1'b1;
            bus_wr_data = dval;
            @(negedge clk_b);
            bus_wr_stb = 1'b0;
            bus_wr_data = ~dval;
            repeat (56) @(negedge clk_b);   // about 40 user cycles
            chk(stb_cnt - base == 1, "R7 delivered in time", stb_cnt - base, 32'd1);
            chk(last_seen == dval, "R6 strobe data", last_seen, dval);
            chk(usr_wr_data == dval, "R6 data held", usr_wr_data, dval);
            repeat (g) @(negedge clk_b);
            chk(stb_cnt - base == 1, "R8 no loss or duplicate", stb_cnt - base, 32'd1);
        end
        chk(wide_cnt == 0, "R6 strobe one cycle wide", wide_cnt, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule